// File: doc/BRIEF.md
# Interleaved-Header Cipher Operation Sequencer

This block sits in front of a block-cipher engine and takes a single byte stream in which every operation starts with a short header followed by its payload. The headers are consumed in hardware. The block reads each header and checks it against a direction policy set by the CPU. It resolves a key index through an on-chip key table and drives the engine's restart, IV-load and key-load strobes. It then feeds exactly the announced number of payload bytes into the engine. Only the engine's results are forwarded, so the output carries fewer bytes than the input.

The stream is cut into batches, and the last byte of a batch is marked with `in_last`. Keys never travel in the stream: a header names a table slot, or it reuses the key of an earlier header for a declared number of following operations. If a header breaks the rules, the rest of the batch is discarded without touching the engine. An error status then reports the cause and the number of the operation within the batch.

Top module: `pseq_top`

## Requirements
- R1: A header opens with a control byte. Bit 0 gives the direction (1 = decrypt), bit 1 means an IV follows, bit 2 means a key index follows, and bits 7:4 give a reuse count. Once a legal control byte is accepted, `eng_start` is high for exactly the next cycle, and `eng_dec` equals bit 0 in that cycle.
- R2: When bit 1 is set, the next 8 bytes form the IV, first byte most significant, and `eng_iv` is presented with an `eng_iv_ld` pulse in the cycle after the eighth byte. When bit 1 is clear, no IV load happens and the engine keeps the all-zero IV it takes on restart.
- R3: When bit 2 is set, the next byte is a key-table index. If it is accepted, `eng_key_ld` pulses two cycles after the index byte, and `eng_key` then holds that table entry.
- R4: A header that carries a key index sets a reuse counter to its bits 7:4. Each later header without a key index decrements that counter. A header without a key index is legal only while the counter is nonzero, and the counter is zero at the start of every batch.
- R5: The last header byte is the payload length L in bytes, and it must be a nonzero multiple of 8. The next L bytes go to the engine, each one shown on `eng_din` with `eng_din_valid` in the cycle after it is accepted. Then a new header begins.
- R6: Each engine result byte appears on `out_data` with `out_valid` one cycle after the engine presents it. Header bytes never reach the output.
- R7: If the CPU policy forbids the requested direction, the error code is 2. Policy bit 0 allows encryption and policy bit 1 allows decryption.
- R8: If the key index is at or above the table size, or names a slot whose valid bit is clear, the error code is 1.
- R9: A bad length gives error code 3. A missing key index while the reuse counter is zero gives code 4. A batch that ends before its last operation's payload is complete gives code 5. These checks are ordered direction, missing key, then truncation on the control byte, and key or length before truncation on later bytes.
- R10: On an error, `err_flag`, `err_code` and `err_op` (the 0-based operation number within the batch) are set in the next cycle. The engine sees no restart, IV load or data until the batch's `in_last` byte has been drained. The status holds until the first byte of the next batch is accepted.
- R11: A CPU key write stores a 64-bit key and a valid bit in one slot, and a policy write replaces both policy bits. Either write is honoured for bytes accepted in later cycles.
- R12: After synchronous reset, every output is zero, no key slot is valid, and both directions are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present; always accepted |
| in_data | input | 8 | Input byte (header or payload) |
| in_last | input | 1 | Marks the final byte of a batch |
| out_valid | output | 1 | Result byte present |
| out_data | output | 8 | Result byte |
| eng_start | output | 1 | Engine restart pulse (IV cleared to zero) |
| eng_dec | output | 1 | Engine direction, 1 = decrypt |
| eng_iv_ld | output | 1 | IV load strobe |
| eng_iv | output | 64 | IV value |
| eng_key_ld | output | 1 | Key load strobe |
| eng_key | output | 64 | Key value |
| eng_din_valid | output | 1 | Payload byte to engine valid |
| eng_din | output | 8 | Payload byte to engine |
| eng_dout_valid | input | 1 | Engine result byte valid |
| eng_dout | input | 8 | Engine result byte |
| cpu_key_we | input | 1 | Key table write strobe |
| cpu_key_idx | input | 3 | Key slot to write |
| cpu_key_val | input | 64 | Key value to write |
| cpu_key_ok | input | 1 | Valid bit written with the key |
| cpu_pol_we | input | 1 | Policy write strobe |
| cpu_pol | input | 2 | Policy: bit 0 encrypt allowed, bit 1 decrypt allowed |
| err_flag | output | 1 | Batch aborted |
| err_code | output | 3 | Abort cause |
| err_op | output | 8 | Operation number of the abort |

## Verification
Most results follow one cycle after the byte that causes them. This holds for the restart pulse, the IV load after the eighth IV byte, each payload byte on the engine side, and the error status. The key load lands two cycles after the index byte because the table read is registered, and a result byte is due one cycle after the engine returns it. The bench keeps a behavioural model that applies the same delays with counters and queues. It compares every output with the model on the falling edge of every clock, so a result that comes a cycle early or late is flagged.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  // Header control-byte field positions
  localparam int F_DIR   = 0;
  localparam int F_IV    = 1;
  localparam int F_KEY   = 2;
  localparam int F_RC_LO = 4;
  localparam int RCW     = 4;

  typedef enum logic [2:0] {
    S_FLAG  = 3'd0,
    S_IV    = 3'd1,
    S_IDX   = 3'd2,
    S_LEN   = 3'd3,
    S_PAY   = 3'd4,
    S_DRAIN = 3'd5
  } seq_st_t;

  typedef enum logic [2:0] {
    E_NONE  = 3'd0,
    E_KEY   = 3'd1,
    E_DIR   = 3'd2,
    E_LEN   = 3'd3,
    E_NOKEY = 3'd4,
    E_TRUNC = 3'd5
  } err_t;

endpackage

// File: rtl/pseq_keytab.sv
module pseq_keytab #(
  parameter int KEYS = 8,
  parameter int KEYW = 64,
  localparam int IDXW = (KEYS > 1) ? $clog2(KEYS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [KEYW-1:0] wr_key,
  input  logic            wr_ok,
  input  logic            pol_we,
  input  logic [1:0]      pol_in,
  input  logic [7:0]      rd_byte,
  output logic            hit,
  output logic [KEYW-1:0] key_q,
  output logic [1:0]      pol
);

  logic [KEYW-1:0] mem [KEYS];
  logic [KEYS-1:0] vld;
  logic [IDXW-1:0] rd_idx;
  logic            rd_in_range;
  logic            wr_in_range;

  assign rd_idx      = rd_byte[IDXW-1:0];
  assign rd_in_range = (32'(rd_byte) < KEYS);
  assign wr_in_range = (32'(wr_idx) < KEYS);
  assign hit         = rd_in_range && vld[rd_idx];

  // Key storage: no reset, synchronous read, suited to block RAM
  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range) mem[wr_idx] <= wr_key;
    key_q <= mem[rd_idx];
  end

  // Valid bits and direction policy need a defined reset state
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      pol <= 2'b11;
    end else begin
      if (wr_en && wr_in_range) vld[wr_idx] <= wr_ok;
      if (pol_we) pol <= pol_in;
    end
  end

  AST_POL_RESET: assert property (@(posedge clk) $past(rst) && !rst |-> pol == 2'b11 && vld == '0) // R12
    else $error("policy/valid not in reset state");

endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
  import pseq_pkg::*;
#(
  parameter int KEYW = 64,
  parameter int IVW  = 64,
  parameter int BLK  = 8,
  parameter int OPW  = 8,
  localparam int IVB  = IVW / 8,
  localparam int IVCW = (IVB > 1) ? $clog2(IVB) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  input  logic [1:0]      pol,
  input  logic            key_hit,
  input  logic [KEYW-1:0] key_q,
  output logic            eng_start,
  output logic            eng_dec,
  output logic            eng_iv_ld,
  output logic [IVW-1:0]  eng_iv,
  output logic            eng_key_ld,
  output logic [KEYW-1:0] eng_key,
  output logic            eng_din_valid,
  output logic [7:0]      eng_din,
  output logic            err_flag,
  output logic [2:0]      err_code,
  output logic [OPW-1:0]  err_op
);

  seq_st_t        st;
  logic [IVW-9:0] iv_sh;
  logic [IVCW-1:0] ivcnt;
  logic           has_iv;
  logic           has_key;
  logic [RCW-1:0] keycnt;
  logic [OPW-1:0] opnum;
  logic [7:0]     remain;
  logic           fresh;
  logic           key_pend;

  logic bad;
  err_t why;
  logic dir_ok;
  logic len_ok;

  assign dir_ok = in_data[F_DIR] ? pol[1] : pol[0];
  assign len_ok = (in_data != 8'd0) && ((in_data & 8'(BLK - 1)) == 8'd0);

  // Header checks for the byte currently offered
  always_comb begin
    bad = 1'b0;
    why = E_NONE;
    if (in_valid) begin
      unique case (st)
        S_FLAG: begin
          if (!dir_ok) begin
            bad = 1'b1; why = E_DIR;
          end else if (!in_data[F_KEY] && keycnt == '0) begin
            bad = 1'b1; why = E_NOKEY;
          end else if (in_last) begin
            bad = 1'b1; why = E_TRUNC;
          end
        end
        S_IV: if (in_last) begin
          bad = 1'b1; why = E_TRUNC;
        end
        S_IDX: begin
          if (!key_hit) begin
            bad = 1'b1; why = E_KEY;
          end else if (in_last) begin
            bad = 1'b1; why = E_TRUNC;
          end
        end
        S_LEN: begin
          if (!len_ok) begin
            bad = 1'b1; why = E_LEN;
          end else if (in_last) begin
            bad = 1'b1; why = E_TRUNC;
          end
        end
        S_PAY: if (in_last && remain != 8'd1) begin
          bad = 1'b1; why = E_TRUNC;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_FLAG;
      iv_sh         <= '0;
      ivcnt         <= '0;
      has_iv        <= 1'b0;
      has_key       <= 1'b0;
      keycnt        <= '0;
      opnum         <= '0;
      remain        <= '0;
      fresh         <= 1'b1;
      key_pend      <= 1'b0;
      eng_start     <= 1'b0;
      eng_dec       <= 1'b0;
      eng_iv_ld     <= 1'b0;
      eng_iv        <= '0;
      eng_key_ld    <= 1'b0;
      eng_key       <= '0;
      eng_din_valid <= 1'b0;
      eng_din       <= '0;
      err_flag      <= 1'b0;
      err_code      <= E_NONE;
      err_op        <= '0;
    end else begin
      eng_start     <= 1'b0;
      eng_iv_ld     <= 1'b0;
      eng_din_valid <= 1'b0;
      eng_key_ld    <= key_pend;
      key_pend      <= 1'b0;
      if (key_pend) eng_key <= key_q;

      if (in_valid && st == S_FLAG && fresh) begin
        err_flag <= 1'b0;
        fresh    <= 1'b0;
      end

      if (bad) begin
        err_flag <= 1'b1;
        err_code <= why;
        err_op   <= opnum;
        if (in_last) begin
          st     <= S_FLAG;
          fresh  <= 1'b1;
          opnum  <= '0;
          keycnt <= '0;
        end else begin
          st <= S_DRAIN;
        end
      end else if (in_valid) begin
        unique case (st)
          S_FLAG: begin
            eng_start <= 1'b1;
            eng_dec   <= in_data[F_DIR];
            has_iv    <= in_data[F_IV];
            has_key   <= in_data[F_KEY];
            ivcnt     <= '0;
            keycnt    <= in_data[F_KEY] ? in_data[F_RC_LO +: RCW] : keycnt - 1'b1;
            st        <= in_data[F_IV] ? S_IV : (in_data[F_KEY] ? S_IDX : S_LEN);
          end
          S_IV: begin
            iv_sh <= {iv_sh[IVW-17:0], in_data};
            ivcnt <= ivcnt + 1'b1;
            if (ivcnt == IVCW'(IVB - 1)) begin
              eng_iv_ld <= 1'b1;
              eng_iv    <= {iv_sh, in_data};
              st        <= has_key ? S_IDX : S_LEN;
            end
          end
          S_IDX: begin
            key_pend <= 1'b1;
            st       <= S_LEN;
          end
          S_LEN: begin
            remain <= in_data;
            st     <= S_PAY;
          end
          S_PAY: begin
            eng_din_valid <= 1'b1;
            eng_din       <= in_data;
            remain        <= remain - 8'd1;
            if (remain == 8'd1) begin
              st <= S_FLAG;
              if (in_last) begin
                fresh  <= 1'b1;
                opnum  <= '0;
                keycnt <= '0;
              end else begin
                opnum <= opnum + 1'b1;
              end
            end
          end
          S_DRAIN: if (in_last) begin
            st     <= S_FLAG;
            fresh  <= 1'b1;
            opnum  <= '0;
            keycnt <= '0;
          end
          default: st <= S_FLAG;
        endcase
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst) eng_start |=> !eng_start) // R1
    else $error("restart longer than one cycle");
  AST_DEC_POLICY: assert property (@(posedge clk) disable iff (rst) eng_start && eng_dec |-> $past(pol[1])) // R7
    else $error("forbidden decrypt started");
  AST_ENC_POLICY: assert property (@(posedge clk) disable iff (rst) eng_start && !eng_dec |-> $past(pol[0])) // R7
    else $error("forbidden encrypt started");
  AST_KEY_AFTER_IDX: assert property (@(posedge clk) disable iff (rst) eng_key_ld |-> $past(st == S_IDX && in_valid, 2)) // R3
    else $error("key load without index byte");
  AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (rst) st == S_DRAIN |=> !(eng_din_valid || eng_start || eng_iv_ld)) // R10
    else $error("engine touched while draining");
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst) err_flag && !(in_valid && st == S_FLAG) |=> err_flag) // R10
    else $error("error status dropped early");
  AST_PAY_REMAIN: assert property (@(posedge clk) disable iff (rst) st == S_PAY |-> remain != 8'd0) // R5
    else $error("payload phase with zero remaining");

endmodule

// File: rtl/pseq_outreg.sv
module pseq_outreg (
  input  logic       clk,
  input  logic       rst,
  input  logic       res_valid,
  input  logic [7:0] res_data,
  output logic       out_valid,
  output logic [7:0] out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= res_valid;
      if (res_valid) out_data <= res_data;
    end
  end

endmodule

// File: rtl/pseq_top.sv
module pseq_top #(
  parameter int KEYS = 8,
  parameter int KEYW = 64,
  parameter int IVW  = 64,
  parameter int BLK  = 8,
  parameter int OPW  = 8,
  localparam int IDXW = (KEYS > 1) ? $clog2(KEYS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            eng_start,
  output logic            eng_dec,
  output logic            eng_iv_ld,
  output logic [IVW-1:0]  eng_iv,
  output logic            eng_key_ld,
  output logic [KEYW-1:0] eng_key,
  output logic            eng_din_valid,
  output logic [7:0]      eng_din,
  input  logic            eng_dout_valid,
  input  logic [7:0]      eng_dout,
  input  logic            cpu_key_we,
  input  logic [IDXW-1:0] cpu_key_idx,
  input  logic [KEYW-1:0] cpu_key_val,
  input  logic            cpu_key_ok,
  input  logic            cpu_pol_we,
  input  logic [1:0]      cpu_pol,
  output logic            err_flag,
  output logic [2:0]      err_code,
  output logic [OPW-1:0]  err_op
);

  logic            key_hit;
  logic [KEYW-1:0] key_q;
  logic [1:0]      pol;

  pseq_keytab #(.KEYS(KEYS), .KEYW(KEYW)) u_keytab (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cpu_key_we),
    .wr_idx  (cpu_key_idx),
    .wr_key  (cpu_key_val),
    .wr_ok   (cpu_key_ok),
    .pol_we  (cpu_pol_we),
    .pol_in  (cpu_pol),
    .rd_byte (in_data),
    .hit     (key_hit),
    .key_q   (key_q),
    .pol     (pol)
  );

  pseq_ctrl #(.KEYW(KEYW), .IVW(IVW), .BLK(BLK), .OPW(OPW)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_last       (in_last),
    .pol           (pol),
    .key_hit       (key_hit),
    .key_q         (key_q),
    .eng_start     (eng_start),
    .eng_dec       (eng_dec),
    .eng_iv_ld     (eng_iv_ld),
    .eng_iv        (eng_iv),
    .eng_key_ld    (eng_key_ld),
    .eng_key       (eng_key),
    .eng_din_valid (eng_din_valid),
    .eng_din       (eng_din),
    .err_flag      (err_flag),
    .err_code      (err_code),
    .err_op        (err_op)
  );

  pseq_outreg u_outreg (
    .clk       (clk),
    .rst       (rst),
    .res_valid (eng_dout_valid),
    .res_data  (eng_dout),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: tb/pseq_top_tb.sv
module pseq_top_tb_top;

  localparam int KEYS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        eng_start, eng_dec, eng_iv_ld, eng_key_ld, eng_din_valid;
  logic [63:0] eng_iv, eng_key;
  logic [7:0]  eng_din;
  logic        eng_dout_valid;
  logic [7:0]  eng_dout;
  logic        cpu_key_we = 1'b0;
  logic [2:0]  cpu_key_idx = '0;
  logic [63:0] cpu_key_val = '0;
  logic        cpu_key_ok = 1'b0;
  logic        cpu_pol_we = 1'b0;
  logic [1:0]  cpu_pol = 2'b11;
  logic        err_flag;
  logic [2:0]  err_code;
  logic [7:0]  err_op;

  always #4 clk = ~clk;  // 125 MHz

  pseq_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_data(out_data),
    .eng_start(eng_start), .eng_dec(eng_dec), .eng_iv_ld(eng_iv_ld), .eng_iv(eng_iv),
    .eng_key_ld(eng_key_ld), .eng_key(eng_key), .eng_din_valid(eng_din_valid), .eng_din(eng_din),
    .eng_dout_valid(eng_dout_valid), .eng_dout(eng_dout),
    .cpu_key_we(cpu_key_we), .cpu_key_idx(cpu_key_idx), .cpu_key_val(cpu_key_val),
    .cpu_key_ok(cpu_key_ok), .cpu_pol_we(cpu_pol_we), .cpu_pol(cpu_pol),
    .err_flag(err_flag), .err_code(err_code), .err_op(err_op)
  );

  // Stand-in engine: one-cycle latency, fixed byte transform
  always @(posedge clk) begin
    if (rst) begin
      eng_dout_valid <= 1'b0;
      eng_dout       <= '0;
    end else begin
      eng_dout_valid <= eng_din_valid;
      eng_dout       <= eng_din ^ 8'h3C;
    end
  end

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    run_chk = 0;
  bit    done = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (%s) act=%h exp=%h at %0t", tag, cur_req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          ph, ivn, kc, opn, rem, code;
  bit          fr, hk, hiv, pend;
  logic [63:0] ivacc, pend_key;
  logic [63:0] tkey [KEYS];
  bit          tv [KEYS];
  bit [1:0]    tpol;
  bit          x_start, x_dec, x_ivld, x_kld, x_dv, x_ov, x_ef, m_ev;
  logic [63:0] x_iv, x_key;
  logic [7:0]  x_d, x_od, m_ed;
  int          x_ec, x_eo;

  task automatic m_batch_end();
    ph = 0; fr = 1; opn = 0; kc = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; ivn = 0; kc = 0; opn = 0; rem = 0; fr = 1; hk = 0; hiv = 0; pend = 0;
      ivacc = '0; pend_key = '0; tpol = 2'b11;
      for (int i = 0; i < KEYS; i++) tv[i] = 0;
      x_start = 0; x_dec = 0; x_ivld = 0; x_kld = 0; x_dv = 0; x_ov = 0; x_ef = 0; m_ev = 0;
      x_iv = '0; x_key = '0; x_d = '0; x_od = '0; m_ed = '0; x_ec = 0; x_eo = 0;
    end else begin
      x_ov = m_ev;
      if (m_ev) x_od = m_ed;
      m_ev = x_dv; m_ed = x_d ^ 8'h3C;
      x_kld = pend;
      if (pend) x_key = pend_key;
      pend = 0; x_start = 0; x_ivld = 0; x_dv = 0;
      if (in_valid) begin
        code = 0;
        if (ph == 0 && fr) begin x_ef = 0; fr = 0; end
        case (ph)
          0: begin
            if (!(in_data[0] ? tpol[1] : tpol[0])) code = 2;
            else if (!in_data[2] && kc == 0) code = 4;
            else if (in_last) code = 5;
            else begin
              x_start = 1; x_dec = in_data[0]; hiv = in_data[1]; hk = in_data[2];
              kc = hk ? int'(in_data[7:4]) : kc - 1;
              ivn = 0;
              ph = hiv ? 1 : (hk ? 2 : 3);
            end
          end
          1: begin
            if (in_last) code = 5;
            else begin
              ivacc = {ivacc[55:0], in_data}; ivn++;
              if (ivn == 8) begin x_ivld = 1; x_iv = ivacc; ph = hk ? 2 : 3; end
            end
          end
          2: begin
            if (int'(in_data) >= KEYS) code = 1;
            else if (!tv[in_data[2:0]]) code = 1;
            else if (in_last) code = 5;
            else begin pend = 1; pend_key = tkey[in_data[2:0]]; ph = 3; end
          end
          3: begin
            if (in_data == 0 || (in_data % 8) != 0) code = 3;
            else if (in_last) code = 5;
            else begin rem = in_data; ph = 4; end
          end
          4: begin
            if (in_last && rem != 1) code = 5;
            else begin
              x_dv = 1; x_d = in_data; rem--;
              if (rem == 0) begin
                if (in_last) m_batch_end();
                else begin ph = 0; opn++; end
              end
            end
          end
          default: if (in_last) m_batch_end();
        endcase
        if (code != 0) begin
          x_ef = 1; x_ec = code; x_eo = opn;
          if (in_last) m_batch_end(); else ph = 5;
        end
      end
      if (cpu_key_we) begin tkey[cpu_key_idx] = cpu_key_val; tv[cpu_key_idx] = cpu_key_ok; end
      if (cpu_pol_we) tpol = cpu_pol;
    end
  end

  // ---------------- every-cycle comparison ----------------
  always @(negedge clk) begin
    if (run_chk && !rst) begin
      chk(eng_start === x_start, "R1 restart", eng_start, x_start);
      if (x_start) chk(eng_dec === x_dec, "R1 direction", eng_dec, x_dec);
      chk(eng_iv_ld === x_ivld, "R2 iv load", eng_iv_ld, x_ivld);
      if (x_ivld) chk(eng_iv === x_iv, "R2 iv value", eng_iv, x_iv);
      chk(eng_key_ld === x_kld, "R3 key load", eng_key_ld, x_kld);
      if (x_kld) chk(eng_key === x_key, "R3 key value", eng_key, x_key);
      chk(eng_din_valid === x_dv, "R5 payload valid", eng_din_valid, x_dv);
      if (x_dv) chk(eng_din === x_d, "R5 payload byte", eng_din, x_d);
      chk(out_valid === x_ov, "R6 out valid", out_valid, x_ov);
      if (x_ov) chk(out_data === x_od, "R6 out byte", out_data, x_od);
      chk(err_flag === x_ef, "R10 err flag", err_flag, x_ef);
      if (x_ef) begin
        chk(err_code === 3'(x_ec), (x_ec == 1) ? "R8 code" : (x_ec == 2) ? "R7 code" : "R9 code",
            err_code, x_ec);
        chk(err_op === 8'(x_eo), "R10 op number", err_op, x_eo);
      end
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] q[$];

  task automatic add_op(input logic [7:0] fl, input logic [7:0] idx, input int len, input logic [7:0] seed);
    q.push_back(fl);
    if (fl[1]) for (int k = 0; k < 8; k++) q.push_back(seed + 8'(k * 17));
    if (fl[2]) q.push_back(idx);
    q.push_back(8'(len));
    for (int k = 0; k < len; k++) q.push_back(seed ^ 8'(k * 7));
  endtask

  task automatic send(input bit gaps);
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = q[i]; in_last = (i == q.size() - 1);
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic wkey(input int idx, input logic [63:0] val, input bit ok);
    @(negedge clk);
    cpu_key_we = 1'b1; cpu_key_idx = 3'(idx); cpu_key_val = val; cpu_key_ok = ok;
    @(negedge clk);
    cpu_key_we = 1'b0;
  endtask

  task automatic wpol(input logic [1:0] p);
    @(negedge clk);
    cpu_pol_we = 1'b1; cpu_pol = p;
    @(negedge clk);
    cpu_pol_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired (all) act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R12";
    chk({out_valid, eng_start, eng_iv_ld, eng_key_ld, eng_din_valid, err_flag} === 6'b0,
        "R12 reset strobes", {out_valid, eng_start, eng_iv_ld, eng_key_ld, eng_din_valid, err_flag}, 0);
    chk({eng_iv, eng_key} === 128'b0 && eng_din === 8'd0, "R12 reset data", eng_key, 0);
    run_chk = 1;

    cur_req = "R11";
    for (int i = 0; i < 4; i++) wkey(i, 64'h1111_0000_0000_0000 * (i + 1) + 64'(i), 1'b1);
    wkey(5, 64'hDEAD_BEEF_0000_0005, 1'b0);

    cur_req = "R2";
    add_op(8'h06, 8'd1, 16, 8'h10);
    add_op(8'h25, 8'd2, 8, 8'h20);
    add_op(8'h01, 8'd0, 8, 8'h30);
    add_op(8'h03, 8'd0, 8, 8'h40);
    send(1'b1);

    cur_req = "R4";
    add_op(8'h14, 8'd0, 8, 8'h50);
    add_op(8'h00, 8'd0, 8, 8'h60);
    add_op(8'h00, 8'd0, 8, 8'h70);
    send(1'b0);

    cur_req = "R8";
    add_op(8'h04, 8'd5, 8, 8'h80);
    send(1'b0);
    add_op(8'h04, 8'd9, 8, 8'h81);
    send(1'b1);

    cur_req = "R7";
    wpol(2'b01);
    add_op(8'h04, 8'd3, 8, 8'h90);
    add_op(8'h05, 8'd1, 8, 8'h91);
    send(1'b0);
    wpol(2'b11);

    cur_req = "R9";
    add_op(8'h04, 8'd1, 12, 8'hA0);
    send(1'b0);
    add_op(8'h04, 8'd1, 0, 8'hA1);
    send(1'b0);
    q.push_back(8'h06); q.push_back(8'h01); q.push_back(8'h02); q.push_back(8'h03);
    send(1'b0);
    add_op(8'h04, 8'd2, 16, 8'hA2);
    void'(q.pop_back());
    send(1'b0);

    cur_req = "R11";
    wkey(5, 64'h0F0E_0D0C_0B0A_0908, 1'b1);
    add_op(8'h04, 8'd5, 16, 8'hB0);
    send(1'b1);

    cur_req = "R5";
    add_op(8'h0E, 8'd3, 64, 8'hC0);
    add_op(8'h04, 8'd0, 248, 8'hC1);
    send(1'b0);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule